// File: doc/BRIEF.md
# Universal bus register transceiver

This block links two 18-bit buses, A and B, with one storage path per direction. The A-to-B path and the B-to-A path each have their own controls. At run time each path can act as a transparent latch, a latch that holds its value, a register that captures on a rising strobe edge, or a register whose strobe edges are gated by an enable. A path drives its output port only while its active-low output enable is low. Each pad is modelled as an input bus, an output bus and a drive flag, so that the block stays synthesizable and the tri-state buffers sit outside it.

The whole block runs on one system clock `clk`. The per-direction strobe is an ordinary data input. The block samples it on `clk` and treats a change from 0 to 1 between two successive `clk` edges as a rising strobe edge. A synchronous reset clears both stored words to zero.

Top module: `univ_bus_xcvr`

## Requirements
- R1: Both data paths are 18 bits wide (parameter `W`, default 18), and every bit passes from input to output.
- R2: While a direction's `*_pass` input is 1, its output bus equals its input bus in the same cycle (combinational path), whatever its strobe and strobe enable are doing.
- R3: While `*_pass` is 0 and no enabled rising strobe edge occurs, the output bus keeps its stored value, even when the input bus changes.
- R4: While `*_pass` is 0 and `*_stb_en_n` is 0, a `clk` edge at which `*_stb` is 1 and was 0 at the previous `clk` edge stores the input bus. The output shows the stored word from that edge onward.
- R5: While `*_stb_en_n` is 1, rising strobe edges leave the stored word unchanged.
- R6: When `*_pass` goes from 1 to 0, the output holds the input word sampled at the last `clk` edge at which `*_pass` was 1.
- R7: A port's drive flag is 1 exactly when the output enable of the direction that feeds it (`ab_oe_n` for port B, `ba_oe_n` for port A) is 0. The output enables are active low.
- R8: The two directions are independent. Controls and data of one direction do not change the other direction's output or stored word.
- R9: A synchronous reset (`rst` = 1 at a `clk` edge) clears both stored words to all zeros. With `*_pass` at 0, the outputs then read zero.
- R10: `*_pass` takes priority over the strobe path. While it is 1, the stored word follows the input at every `clk` edge, whatever the strobe and strobe enable are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data received from bus A |
| a_out | output | 18 | Data for bus A (from the B-to-A path) |
| a_drive | output | 1 | Drive flag for bus A pads |
| b_in | input | 18 | Data received from bus B |
| b_out | output | 18 | Data for bus B (from the A-to-B path) |
| b_drive | output | 1 | Drive flag for bus B pads |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_pass | input | 1 | A-to-B transparent control |
| ab_stb | input | 1 | A-to-B capture strobe |
| ab_stb_en_n | input | 1 | A-to-B strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_pass | input | 1 | B-to-A transparent control |
| ba_stb | input | 1 | B-to-A capture strobe |
| ba_stb_en_n | input | 1 | B-to-A strobe enable, active low |

## Verification
The hardest case to reach from the ports is a falling transparent control while the strobe enable is high. The word held afterwards must be the one sampled at the last edge of transparency, and a strobe rising at the same moment must not replace it. The stimulus produces this by changing the input bus on the same cycle that `*_pass` falls, and then toggling the strobe with the enable off. A second sequence toggles the strobe while `*_pass` is high, to show that the strobe path has no effect during transparency. A mid-run reset with `*_pass` low exposes the cleared stored words directly at the outputs.

// File: rtl/univ_bus_xcvr.sv
module univ_bus_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  input  logic         ab_oe_n,
  input  logic         ab_pass,
  input  logic         ab_stb,
  input  logic         ab_stb_en_n,
  input  logic         ba_oe_n,
  input  logic         ba_pass,
  input  logic         ba_stb,
  input  logic         ba_stb_en_n
);
  localparam int NDIR = 2;

  logic [NDIR-1:0][W-1:0] din, dout, held;
  logic [NDIR-1:0]        pass, stb, stb_en_n, stb_q, oe_n;

  assign din      = {b_in, a_in};
  assign pass     = {ba_pass, ab_pass};
  assign stb      = {ba_stb, ab_stb};
  assign stb_en_n = {ba_stb_en_n, ab_stb_en_n};
  assign oe_n     = {ba_oe_n, ab_oe_n};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic take;
    assign take = pass[d] | (stb[d] & ~stb_q[d] & ~stb_en_n[d]);

    always_ff @(posedge clk) begin
      stb_q[d] <= stb[d];
      if (rst)       held[d] <= '0;
      else if (take) held[d] <= din[d];
    end

    assign dout[d] = pass[d] ? din[d] : held[d];
  end

  assign b_out   = dout[0];
  assign a_out   = dout[1];
  assign b_drive = ~oe_n[0];
  assign a_drive = ~oe_n[1];
endmodule

module univ_bus_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_drive,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_drive,
  input logic         ab_oe_n,
  input logic         ab_pass,
  input logic         ab_stb,
  input logic         ab_stb_en_n,
  input logic         ba_oe_n,
  input logic         ba_pass,
  input logic         ba_stb,
  input logic         ba_stb_en_n
);
  assert_ab_transparent_R2: assert property (@(posedge clk) disable iff (rst)
    ab_pass |-> b_out == a_in);
  assert_ba_transparent_R2: assert property (@(posedge clk) disable iff (rst)
    ba_pass |-> a_out == b_in);
  assert_ab_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && !(ab_stb && !$past(ab_stb) && !ab_stb_en_n))
      |=> (ab_pass || b_out == $past(b_out)));
  assert_ab_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && ab_stb && !$past(ab_stb) && !ab_stb_en_n)
      |=> (ab_pass || b_out == $past(a_in)));
  assert_ba_gated_R5: assert property (@(posedge clk) disable iff (rst)
    (!ba_pass && ba_stb_en_n) |=> (ba_pass || a_out == $past(a_out)));
  assert_b_drive_R7: assert property (@(posedge clk) ab_oe_n |-> !b_drive);
  assert_a_drive_R7: assert property (@(posedge clk) !ba_oe_n |-> a_drive);
  assert_reset_clear_R9: assert property (@(posedge clk)
    ($past(rst) && !ab_pass && !ba_pass) |-> (a_out == '0 && b_out == '0));
endmodule

bind univ_bus_xcvr univ_bus_xcvr_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
  .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
  .ab_oe_n(ab_oe_n), .ab_pass(ab_pass), .ab_stb(ab_stb), .ab_stb_en_n(ab_stb_en_n),
  .ba_oe_n(ba_oe_n), .ba_pass(ba_pass), .ba_stb(ba_stb), .ba_stb_en_n(ba_stb_en_n)
);

// File: tb/univ_bus_xcvr_tb_top.sv
module univ_bus_xcvr_tb_top;
  localparam int W = 18;

  logic clk = 0, rst = 1;
  logic [W-1:0] a_in = '0, b_in = '0, a_out, b_out;
  logic a_drive, b_drive;
  logic ab_oe_n = 1, ab_pass = 0, ab_stb = 0, ab_stb_en_n = 1;
  logic ba_oe_n = 1, ba_pass = 0, ba_stb = 0, ba_stb_en_n = 1;

  int checks = 0, fails = 0;
  string tag = "R9";

  always #5 clk = ~clk;

  univ_bus_xcvr #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .ab_oe_n(ab_oe_n), .ab_pass(ab_pass), .ab_stb(ab_stb), .ab_stb_en_n(ab_stb_en_n),
    .ba_oe_n(ba_oe_n), .ba_pass(ba_pass), .ba_stb(ba_stb), .ba_stb_en_n(ba_stb_en_n)
  );

  // reference model: stored words and last seen strobe levels
  logic [W-1:0] m_ab, m_ba;
  logic m_ab_prev, m_ba_prev;
  always @(posedge clk) begin
    if (rst) begin
      m_ab <= '0;
      m_ba <= '0;
    end else begin
      if (ab_pass || (ab_stb && !m_ab_prev && !ab_stb_en_n)) m_ab <= a_in;
      if (ba_pass || (ba_stb && !m_ba_prev && !ba_stb_en_n)) m_ba <= b_in;
    end
    m_ab_prev <= ab_stb;
    m_ba_prev <= ba_stb;
  end

  task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    #1;
    chk("b_out", b_out, ab_pass ? a_in : m_ab);
    chk("a_out", a_out, ba_pass ? b_in : m_ba);
    chk("b_drive", W'(b_drive), W'(!ab_oe_n));
    chk("a_drive", W'(a_drive), W'(!ba_oe_n));
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(posedge clk); #2;
    @(posedge clk); #2;
    tag = "R9"; cyc();
    chk("b_out reset zero", b_out, '0);
    chk("a_out reset zero", a_out, '0);
    rst = 0; cyc(); cyc();

    // R1 / R2: transparent, full-width patterns
    tag = "R1"; ab_pass = 1; ba_pass = 1; ab_oe_n = 0; ba_oe_n = 0;
    a_in = '1; b_in = 18'h2AAAA; cyc();
    chk("b_out all ones R1", b_out, 18'h3FFFF);
    tag = "R2";
    for (int i = 0; i < 6; i++) begin
      a_in = W'(18'h00001 << (i * 3)); b_in = ~a_in;
      ab_stb = i[0]; ba_stb = ~i[0];
      cyc();
    end

    // R6: pass falls, input changes at once
    tag = "R6"; a_in = 18'h1C0DE; b_in = 18'h0BEEF; cyc();
    ab_pass = 0; ba_pass = 0; a_in = 18'h3F00F; b_in = 18'h00FF0; cyc();
    chk("b_out held R6", b_out, 18'h1C0DE);
    chk("a_out held R6", a_out, 18'h0BEEF);

    // R3: steady strobes at both levels
    tag = "R3"; ab_stb = 1; ba_stb = 1; cyc();
    for (int i = 0; i < 4; i++) begin a_in = a_in + 18'h111; b_in = b_in ^ 18'h3; cyc(); end
    ab_stb = 0; ba_stb = 0; cyc(); cyc();

    // R4: enabled rising edges capture
    tag = "R4"; ab_stb_en_n = 0; ba_stb_en_n = 0;
    for (int i = 0; i < 4; i++) begin
      a_in = 18'h12345 + W'(i); b_in = 18'h2468A - W'(i);
      ab_stb = 1; ba_stb = 1; cyc();
      ab_stb = 0; ba_stb = 0; a_in = 18'h0; b_in = 18'h0; cyc();
    end
    chk("b_out captured R4", b_out, 18'h12348);

    // R5: gated strobe edges ignored
    tag = "R5"; ab_stb_en_n = 1; ba_stb_en_n = 1;
    for (int i = 0; i < 4; i++) begin
      a_in = 18'h3ACE0 + W'(i); b_in = 18'h15A50; ab_stb = ~ab_stb; ba_stb = ~ba_stb; cyc();
    end
    chk("b_out unchanged R5", b_out, 18'h12348);

    // R10: pass overrides a gated strobe and a steady strobe
    tag = "R10"; ab_pass = 1;
    for (int i = 0; i < 4; i++) begin a_in = 18'h05555 << i; ab_stb = ~ab_stb; cyc(); end
    ab_pass = 0; cyc();
    chk("b_out last pass word R10", b_out, W'(18'h05555 << 3));

    // R7: output enables
    tag = "R7"; ab_oe_n = 1; cyc(); ba_oe_n = 1; cyc(); ab_oe_n = 0; cyc(); ba_oe_n = 0; cyc();

    // R8: one direction active, the other holds
    tag = "R8"; ba_stb_en_n = 0; ab_stb_en_n = 1;
    for (int i = 0; i < 4; i++) begin
      b_in = 18'h00C00 + W'(i); ba_stb = 1; a_in = ~b_in; ab_stb = ~ab_stb; cyc();
      ba_stb = 0; cyc();
    end
    chk("b_out untouched R8", b_out, W'(18'h05555 << 3));
    ab_pass = 1; a_in = 18'h3C3C3; cyc();
    chk("a_out untouched R8", a_out, 18'h00C03);
    ab_pass = 0;

    // R9: reset mid-run
    tag = "R9"; rst = 1; cyc(); cyc();
    rst = 0; cyc();
    chk("b_out cleared R9", b_out, '0);
    chk("a_out cleared R9", a_out, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule